// File: doc/BRIEF.md
# Buck Channel Light-Load Mode Sequencer

This block controls the mode and the power-switch sequencing for one channel of a synchronous step-down converter. Its inputs are digital comparator flags and a strobe that marks the start of each switching period. In fixed-frequency PWM, the high-side request follows an externally generated duty request. That request is cut short by the cycle-by-cycle current limit. The low-side switch rectifies for the remainder of the period.

When the load stays light for a qualified run of switching periods, the channel drops into pulse-frequency mode (PFM). The block then runs a burst sequence. The high side charges the output until the output reaches the upper threshold or the current reaches the PFM peak limit. The low side then drains the inductor to zero current. After that the channel sleeps with both switches off until the output sags below the lower threshold.

A deeper sag below a separate, lower threshold returns the channel to PWM. A forced-PWM control bit overrides all of this. Every handover between the two switches passes through one clock of dead time.

Top module: `buck_mode_seq`

## Requirements
- R1: While `en` is low, both gate requests are low one clock later, the mode reads PWM (`mode_pfm`=0), and the light-load qualification count restarts from zero.
- R2: In auto mode (`force_pwm`=0) in PWM, a strobe cycle with `izero` or `ipk_below_mode` high counts as light. `mode_pfm` rises on the clock edge that samples the 32nd consecutive light strobe (QUAL_CYCLES=32).
- R3: A strobe cycle with neither light flag high clears the qualification count. A further full run of 32 light strobes is then needed. The count is also zero after leaving PFM.
- R4: With `force_pwm` high, `mode_pfm` is low one clock later and stays low regardless of light-load strobes.
- R5: In PFM, `cmp_below_low2` high returns the mode to PWM on the next clock edge.
- R6: In PWM, `pfet_on` follows `pwm_on_req`, and `nfet_on` is its complement. A change of the request reaches the gate outputs one clock later, or two clocks later when a handover dead time is needed.
- R7: In PWM, `ilim_trip` forces `pfet_on` low from the next clock. The high side stays blocked until the next `cyc_stb` clears the block.
- R8: In PFM sleep, both gates are off. `cmp_below_low` starts a burst, and `pfet_on` rises two clocks after it is sampled.
- R9: During a PFM burst, the high side stays on while `cmp_below_high` is high and `ipk_at_pfm_lim` is low. When either condition ends, the low side turns on after one dead-time clock and stays on until `izero`.
- R10: On `izero` in the PFM drain phase, the channel charges again if `cmp_below_high` is high. Otherwise it returns to sleep with both gates off.
- R11: `pfet_on` and `nfet_on` are never high together. The clock after either one is high, the other is low (one clock of dead time).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable |
| cyc_stb | input | 1 | One-clock pulse at the start of each switching period |
| force_pwm | input | 1 | Hold the channel in PWM |
| pwm_on_req | input | 1 | High-side request from the PWM duty generator |
| cmp_below_high | input | 1 | Output below the upper PFM threshold |
| cmp_below_low | input | 1 | Output below the lower PFM threshold |
| cmp_below_low2 | input | 1 | Output below the PFM exit threshold |
| izero | input | 1 | Inductor current at zero |
| ipk_below_mode | input | 1 | Peak high-side current below the mode threshold |
| ipk_at_pfm_lim | input | 1 | Peak current has reached the PFM limit |
| ilim_trip | input | 1 | PWM cycle-by-cycle current limit tripped |
| pfet_on | output | 1 | High-side switch request |
| nfet_on | output | 1 | Low-side switch request |
| mode_pfm | output | 1 | 1 = PFM, 0 = PWM |

## Verification
The checker watches every clock for gate overlap and the dead time at each handover. It also checks that disable, forced PWM and the exit threshold each push the mode to PWM, and that a current-limit trip in PWM turns the high side off. Only the bench scenarios can show the 32-strobe qualification and its restart after a dark strobe, an enable drop or a PFM exit. The bench also walks the burst order through charge, drain and sleep in both of its exit branches, and checks that the current-limit block lasts until the next period strobe.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;
    typedef enum logic {
        MODE_PWM = 1'b0,
        MODE_PFM = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        BST_SLEEP  = 2'd0,
        BST_CHARGE = 2'd1,
        BST_DRAIN  = 2'd2
    } burst_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_t;
endpackage

// File: rtl/bmq_qual.sv
module bmq_qual #(
    parameter int unsigned QUAL_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic active,
    input  logic cyc_stb,
    input  logic light,
    output logic enter
);
    localparam int unsigned CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } qual_t;

    qual_t q_d, q_q;

    always_comb begin
        q_d   = q_q;
        enter = 1'b0;
        if (!en || !active) begin
            q_d.cnt = '0;
        end else if (cyc_stb) begin
            if (light) begin
                if (q_q.cnt == LAST) begin
                    enter   = 1'b1;
                    q_d.cnt = '0;
                end else begin
                    q_d.cnt = q_q.cnt + 1'b1;
                end
            end else begin
                q_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end
endmodule

// File: rtl/bmq_burst.sv
module bmq_burst
    import buck_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic below_low,
    input  logic below_high,
    input  logic pk_lim,
    input  logic izero,
    output logic hi_want,
    output logic lo_want
);
    typedef struct packed {
        burst_e st;
    } burst_t;

    burst_t b_d, b_q;

    always_comb begin
        b_d     = b_q;
        hi_want = 1'b0;
        lo_want = 1'b0;
        if (!run) begin
            b_d.st = BST_SLEEP;
        end else begin
            case (b_q.st)
                BST_SLEEP: begin
                    if (below_low) b_d.st = BST_CHARGE;
                end
                BST_CHARGE: begin
                    hi_want = 1'b1;
                    if (!below_high || pk_lim) b_d.st = BST_DRAIN;
                end
                BST_DRAIN: begin
                    lo_want = 1'b1;
                    if (izero) b_d.st = below_high ? BST_CHARGE : BST_SLEEP;
                end
                default: b_d.st = BST_SLEEP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '{st: BST_SLEEP};
        else        b_q <= b_d;
    end
endmodule

// File: rtl/bmq_gate.sv
module bmq_gate
    import buck_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hi_want,
    input  logic lo_want,
    output logic hi_on,
    output logic lo_on
);
    gate_t g_d, g_q;

    always_comb begin
        g_d.hi = en && hi_want && !g_q.lo;
        g_d.lo = en && lo_want && !g_q.hi && !hi_want;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign hi_on = g_q.hi;
    assign lo_on = g_q.lo;
endmodule

// File: rtl/buck_mode_seq.sv
module buck_mode_seq
    import buck_mode_pkg::*;
#(
    parameter int unsigned QUAL_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cyc_stb,
    input  logic force_pwm,
    input  logic pwm_on_req,
    input  logic cmp_below_high,
    input  logic cmp_below_low,
    input  logic cmp_below_low2,
    input  logic izero,
    input  logic ipk_below_mode,
    input  logic ipk_at_pfm_lim,
    input  logic ilim_trip,
    output logic pfet_on,
    output logic nfet_on,
    output logic mode_pfm
);
    typedef struct packed {
        mode_e mode;
        logic  blk;
    } top_t;

    top_t t_d, t_q;
    logic enter_pfm;
    logic qual_active;
    logic burst_run;
    logic bhi, blo;
    logic hi_want, lo_want;
    logic pwm_hi;

    assign qual_active = (t_q.mode == MODE_PWM) && !force_pwm;
    assign burst_run   = en && (t_q.mode == MODE_PFM);

    bmq_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .active (qual_active),
        .cyc_stb(cyc_stb),
        .light  (izero || ipk_below_mode),
        .enter  (enter_pfm)
    );

    bmq_burst u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (burst_run),
        .below_low (cmp_below_low),
        .below_high(cmp_below_high),
        .pk_lim    (ipk_at_pfm_lim),
        .izero     (izero),
        .hi_want   (bhi),
        .lo_want   (blo)
    );

    always_comb begin
        t_d = t_q;
        if (!en) begin
            t_d.mode = MODE_PWM;
            t_d.blk  = 1'b0;
        end else begin
            case (t_q.mode)
                MODE_PWM: if (!force_pwm && enter_pfm) t_d.mode = MODE_PFM;
                MODE_PFM: if (force_pwm || cmp_below_low2) t_d.mode = MODE_PWM;
                default:  t_d.mode = MODE_PWM;
            endcase
            t_d.blk = (t_q.mode == MODE_PWM) && ((t_q.blk && !cyc_stb) || ilim_trip);
        end
    end

    always_comb begin
        pwm_hi = pwm_on_req && !ilim_trip && !t_q.blk;
        if (!en) begin
            hi_want = 1'b0;
            lo_want = 1'b0;
        end else if (t_q.mode == MODE_PWM) begin
            hi_want = pwm_hi;
            lo_want = !pwm_hi;
        end else begin
            hi_want = bhi;
            lo_want = blo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{mode: MODE_PWM, blk: 1'b0};
        else        t_q <= t_d;
    end

    bmq_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .hi_want(hi_want),
        .lo_want(lo_want),
        .hi_on  (pfet_on),
        .lo_on  (nfet_on)
    );

    assign mode_pfm = (t_q.mode == MODE_PFM);
endmodule

// File: rtl/bmq_chk.sv
module bmq_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic force_pwm,
    input logic cmp_below_low2,
    input logic ilim_trip,
    input logic pfet_on,
    input logic nfet_on,
    input logic mode_pfm
);
    // R11
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pfet_on && nfet_on));
    // R11
    hi_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pfet_on |=> !nfet_on);
    // R11
    lo_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nfet_on |=> !pfet_on);
    // R1
    disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pfet_on && !nfet_on && !mode_pfm));
    // R4
    force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_pwm |=> !mode_pfm);
    // R5
    low2_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode_pfm && cmp_below_low2) |=> !mode_pfm);
    // R7
    ilim_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !mode_pfm && ilim_trip) |=> !pfet_on);
endmodule

bind buck_mode_seq bmq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .force_pwm     (force_pwm),
    .cmp_below_low2(cmp_below_low2),
    .ilim_trip     (ilim_trip),
    .pfet_on       (pfet_on),
    .nfet_on       (nfet_on),
    .mode_pfm      (mode_pfm)
);

// File: tb/tb_buck_mode_seq.sv
module tb_buck_mode_seq;
    localparam int CLK_PERIOD = 10;
    localparam int QUAL = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, cyc_stb = 1'b0, force_pwm = 1'b0, pwm_on_req = 1'b0;
    logic cmp_below_high = 1'b0, cmp_below_low = 1'b0, cmp_below_low2 = 1'b0;
    logic izero = 1'b0, ipk_below_mode = 1'b0, ipk_at_pfm_lim = 1'b0, ilim_trip = 1'b0;
    logic pfet_on, nfet_on, mode_pfm;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    buck_mode_seq #(.QUAL_CYCLES(QUAL)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cyc_stb(cyc_stb), .force_pwm(force_pwm),
        .pwm_on_req(pwm_on_req), .cmp_below_high(cmp_below_high),
        .cmp_below_low(cmp_below_low), .cmp_below_low2(cmp_below_low2),
        .izero(izero), .ipk_below_mode(ipk_below_mode), .ipk_at_pfm_lim(ipk_at_pfm_lim),
        .ilim_trip(ilim_trip), .pfet_on(pfet_on), .nfet_on(nfet_on), .mode_pfm(mode_pfm)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {pfet_on, nfet_on, mode_pfm};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {p,n,mode} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_mode(input string req, input logic exp);
        n_run++;
        if (mode_pfm !== exp) begin
            n_fail++;
            $display("FAIL %s: mode_pfm actual %b expected %b", req, mode_pfm, exp);
        end
    endtask

    // one strobe cycle, light flag chosen by kind: 0 none, 1 izero, 2 peak-below-mode
    task automatic strobe(input int kind);
        cyc_stb = 1'b1;
        izero = (kind == 1);
        ipk_below_mode = (kind == 2);
        tick(1);
        cyc_stb = 1'b0;
        izero = 1'b0;
        ipk_below_mode = 1'b0;
        tick(1);
    endtask

    task automatic to_pwm();
        force_pwm = 1'b1;
        tick(1);
        force_pwm = 1'b0;
        tick(1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(2);
        chk("R1 reset/disabled", 3'b000);

        // R6 PWM with low request: low side on
        en = 1'b1;
        tick(1);
        chk("R6 rectify", 3'b010);
        pwm_on_req = 1'b1;
        tick(1);
        chk("R11 dead time to high", 3'b000);
        tick(1);
        chk("R6 high side follows", 3'b100);
        pwm_on_req = 1'b0;
        tick(1);
        chk("R11 dead time to low", 3'b000);
        tick(1);
        chk("R6 low side", 3'b010);

        // R7 current limit
        pwm_on_req = 1'b1;
        tick(2);
        chk("R7 pre", 3'b100);
        ilim_trip = 1'b1;
        tick(1);
        ilim_trip = 1'b0;
        chk("R7 cut", 3'b000);
        tick(3);
        chk("R7 held off", 3'b010);
        strobe(0);
        chk("R7 dead after strobe", 3'b000);
        tick(1);
        chk("R7 resumed", 3'b100);
        pwm_on_req = 1'b0;
        tick(2);

        // R2/R3 sweep of break position
        for (int b = 0; b < QUAL; b++) begin
            for (int i = 0; i < b; i++) strobe(1 + (i % 2));
            strobe(0);
            for (int i = 0; i < QUAL - 1; i++) strobe(1 + ((i + b) % 2));
            chk_mode("R3 dark strobe restarts count", 1'b0);
            cyc_stb = 1'b1;
            izero = 1'b1;
            tick(1);
            cyc_stb = 1'b0;
            izero = 1'b0;
            chk_mode("R2 entry on 32nd light strobe", 1'b1);
            tick(1);
            to_pwm();
        end

        // R3 exit clears count: 31 light strobes after exit stay PWM
        for (int i = 0; i < QUAL - 1; i++) strobe(2);
        chk_mode("R3 count zero after exit", 1'b0);
        // R1 en drop restarts count
        en = 1'b0;
        tick(1);
        en = 1'b1;
        for (int i = 0; i < QUAL - 1; i++) strobe(1);
        chk_mode("R1 count restart", 1'b0);
        strobe(1);
        chk_mode("R2 entry after enable", 1'b1);

        // R4 force exits and holds
        force_pwm = 1'b1;
        tick(1);
        chk_mode("R4 force exit", 1'b0);
        for (int i = 0; i < QUAL + 8; i++) strobe(1);
        chk_mode("R4 force holds PWM", 1'b0);
        force_pwm = 1'b0;
        tick(1);

        // enter PFM, check sleep and burst (R8-R10)
        for (int i = 0; i < QUAL; i++) strobe(1);
        tick(1);
        chk("R8 sleep both off", 3'b001);
        cmp_below_high = 1'b1;
        cmp_below_low = 1'b1;
        tick(1);
        chk("R8 charge pending", 3'b001);
        cmp_below_low = 1'b0;
        tick(1);
        chk("R8 charge", 3'b101);
        tick(3);
        chk("R9 charge holds", 3'b101);
        cmp_below_high = 1'b0;
        tick(1);
        chk("R9 still on at edge", 3'b101);
        tick(1);
        chk("R11 dead in burst", 3'b001);
        tick(1);
        chk("R9 drain", 3'b011);
        tick(2);
        chk("R9 drain holds", 3'b011);
        izero = 1'b1;
        tick(1);
        izero = 1'b0;
        tick(1);
        chk("R10 sleep after drain", 3'b001);
        tick(3);
        chk("R10 stays asleep", 3'b001);

        // peak limit branch, recharge after drain
        cmp_below_low = 1'b1;
        cmp_below_high = 1'b1;
        tick(1);
        cmp_below_low = 1'b0;
        tick(1);
        chk("R8 second burst", 3'b101);
        ipk_at_pfm_lim = 1'b1;
        tick(1);
        ipk_at_pfm_lim = 1'b0;
        tick(2);
        chk("R9 peak limit drain", 3'b011);
        izero = 1'b1;
        tick(1);
        izero = 1'b0;
        chk("R10 drain ending", 3'b011);
        tick(1);
        chk("R11 dead to recharge", 3'b001);
        tick(1);
        chk("R10 recharge", 3'b101);

        // R5 exit via low2
        cmp_below_low2 = 1'b1;
        tick(1);
        cmp_below_low2 = 1'b0;
        chk_mode("R5 low2 exit", 1'b0);
        cmp_below_high = 1'b0;
        tick(2);

        // R1 disable from PFM
        for (int i = 0; i < QUAL; i++) strobe(2);
        chk_mode("R2 re-entry", 1'b1);
        en = 1'b0;
        tick(1);
        chk("R1 disable", 3'b000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule